// File: doc/BRIEF.md
# Overlapped Fault Search Decoder

This block finds one defective element among `N_RES` routing resources on a wire that has already been shown to fail. Each resource carries a binary index of `K = log2(N_RES)` bits. The block drives a fixed schedule of `K` trial configurations. Configuration `k` takes out of the wire every resource whose index has bit `k` equal to 1. The schedule does not depend on any result, so an external agent can accept all configurations back to back, reroute and test each one, and return the outcomes later in any order.

Each outcome is tagged with its configuration number and carries one pass/fail bit. A passing trial means the defect was among the removed resources, so bit `k` of the faulty index is 1. A failing trial means the defect stayed on the wire, so that bit is 0. When every configuration has reported once, the collected bits are the index of the faulty resource. A repeated report for a configuration is flagged and leaves the stored bit unchanged. A start pulse clears the previous search and begins a new one.

Top module: `overlap_fault_locator`

## Requirements
- R1: After reset, issue_valid, done, dup_err and fault_idx are all 0.
- R2: On the clock edge that samples start, issue_valid rises with issue_cfg = 0. The offered number stays unchanged while issue_ready is low. It advances by one on each edge where issue_valid and issue_ready are both high. After configuration K-1 is accepted, issue_valid falls.
- R3: issue_mask bit r is 1 exactly when bit issue_cfg of r is 1, so exactly N_RES/2 bits are set (N_RES = 8: cfg 0 gives 8'hAA, cfg 1 gives 8'hCC, cfg 2 gives 8'hF0). issue_mask is 0 while issue_valid is low.
- R4: A result with res_pass = 1 stores a 1 in bit res_cfg of the fault index. A result with res_pass = 0 stores a 0 there.
- R5: Results are accepted in any order and do not depend on issue progress. done rises on the edge that accepts the last configuration not yet reported.
- R6: fault_idx reads 0 while done is low. It shows the assembled index while done is high.
- R7: A second result for a configuration that has already reported sets dup_err, and leaves the stored bit and done unchanged. dup_err stays set until the next start.
- R8: A result whose res_cfg is K or more is ignored: it stores nothing and does not set dup_err.
- R9: Results before the first start are ignored. start clears all stored results and dup_err. A result sampled on the same edge as start is dropped.
- R10: With N_RES = 8 and resource 1 faulty, the results are cfg 0 pass, cfg 1 fail and cfg 2 fail, and fault_idx is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begins a new search and clears the previous one |
| issue_valid | output | 1 | A configuration is being offered |
| issue_ready | input | 1 | The consumer accepts the offered configuration |
| issue_cfg | output | CW | Number of the offered configuration |
| issue_mask | output | N_RES | Resources removed by the offered configuration |
| res_valid | input | 1 | A trial result is present |
| res_cfg | input | CW | Configuration number of the result |
| res_pass | input | 1 | 1 if the rerouted wire passed, 0 if it failed |
| done | output | 1 | Every configuration has reported |
| fault_idx | output | K | Index of the faulty resource, 0 until done |
| dup_err | output | 1 | A configuration reported more than once since start |

## Verification
The locator is swept over every one of the eight possible faulty indices. Each index is run with forward, reverse and rotated arrival orders of the results. This separates a bit-to-position mapping error from an ordering dependence, and shows that done waits for the last distinct tag in each order.

The issue path is driven with a stalled ready, to confirm the offer is held, and then drained. Each mask is compared with the value expected for its configuration number.

Separate runs inject the following and check that each leaves the assembled index intact:
- a duplicate result of opposite polarity, both before and after done
- an out-of-range tag
- results sent before any start
- a result sampled on the same edge as start

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic {
    ISS_IDLE  = 1'b0,
    ISS_OFFER = 1'b1
  } iss_state_e;

  function automatic int cfg_width(input int n_cfg);
    return (n_cfg > 1) ? $clog2(n_cfg) : 1;
  endfunction

endpackage

// File: rtl/ofs_rst_sync.sv
module ofs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ofs_issue_seq.sv
module ofs_issue_seq #(
  parameter int N_CFG = 3,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ready,
  output logic          valid,
  output logic [CW-1:0] cfg
);
  import ofs_pkg::*;

  localparam logic [CW-1:0] LAST_CFG = CW'(N_CFG - 1);

  iss_state_e    state_q, state_d;
  logic [CW-1:0] cfg_q, cfg_d;
  logic          accept;

  assign accept = (state_q == ISS_OFFER) && ready;

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    if (start) begin
      state_d = ISS_OFFER;
      cfg_d   = '0;
    end else if (accept) begin
      if (cfg_q == LAST_CFG) begin
        state_d = ISS_IDLE;
      end else begin
        cfg_d = cfg_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ISS_IDLE;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
    end
  end

  assign valid = (state_q == ISS_OFFER);
  assign cfg   = cfg_q;

  // R2: an offer that is not taken is held unchanged
  a_r2_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !start) |=> (valid && $stable(cfg)));

  // R2: start always opens an offer at configuration 0
  a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid && cfg == '0));

endmodule

// File: rtl/ofs_mask_gen.sv
module ofs_mask_gen #(
  parameter int N_RES = 8,
  parameter int N_CFG = 3,
  parameter int CW    = 2
) (
  input  logic             en,
  input  logic [CW-1:0]    cfg,
  output logic [N_RES-1:0] mask
);

  for (genvar r = 0; r < N_RES; r++) begin : g_res
    localparam logic [N_CFG-1:0] RIDX = N_CFG'(r);
    logic sel;
    always_comb begin
      sel = 1'b0;
      for (int k = 0; k < N_CFG; k++) begin
        if (int'(cfg) == k) sel = RIDX[k];
      end
    end
    assign mask[r] = en & sel;
  end

  // R3: every issued configuration removes exactly half of the resources
  always_comb begin
    if (en) a_r3_half_removed: assert ($countones(mask) == N_RES / 2);
    else    a_r3_idle_empty:   assert (mask == '0);
  end

endmodule

// File: rtl/ofs_collect.sv
module ofs_collect #(
  parameter int N_CFG = 3,
  parameter int CW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             res_valid,
  input  logic [CW-1:0]    res_cfg,
  input  logic             res_pass,
  output logic             done,
  output logic [N_CFG-1:0] pattern,
  output logic             dup_err
);

  logic             active_q, active_d;
  logic [N_CFG-1:0] seen_q, seen_d;
  logic [N_CFG-1:0] pat_q, pat_d;
  logic             err_q, err_d;
  logic [N_CFG-1:0] hit;
  logic             take;
  logic             repeat_hit;

  for (genvar k = 0; k < N_CFG; k++) begin : g_tag
    assign hit[k] = (int'(res_cfg) == k);
  end

  assign take       = active_q && res_valid && (|hit);
  assign repeat_hit = |(hit & seen_q);

  always_comb begin
    active_d = active_q;
    seen_d   = seen_q;
    pat_d    = pat_q;
    err_d    = err_q;
    if (start) begin
      active_d = 1'b1;
      seen_d   = '0;
      pat_d    = '0;
      err_d    = 1'b0;
    end else if (take) begin
      if (repeat_hit) begin
        err_d = 1'b1;
      end else begin
        seen_d = seen_q | hit;
        pat_d  = (pat_q & ~hit) | (hit & {N_CFG{res_pass}});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      seen_q   <= '0;
      pat_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      seen_q   <= seen_d;
      pat_q    <= pat_d;
      err_q    <= err_d;
    end
  end

  assign done    = &seen_q;
  assign pattern = done ? pat_q : '0;
  assign dup_err = err_q;

  // R7: a repeated tag never alters the stored bits
  a_r7_repeat_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (take && repeat_hit && !start) |=> $stable(pat_q));

  // R7: the error flag stays set until the next start
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_err && !start) |=> dup_err);

  // R5: completion only follows an accepted result
  a_r5_done_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(res_valid));

  // R9: start clears completion and error
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !dup_err));

endmodule

// File: rtl/overlap_fault_locator.sv
module overlap_fault_locator #(
  parameter int N_RES = 8,
  localparam int K    = $clog2(N_RES),
  localparam int CW   = ofs_pkg::cfg_width(K)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [CW-1:0]    issue_cfg,
  output logic [N_RES-1:0] issue_mask,
  input  logic             res_valid,
  input  logic [CW-1:0]    res_cfg,
  input  logic             res_pass,
  output logic             done,
  output logic [K-1:0]     fault_idx,
  output logic             dup_err
);

  logic rst_sync_n;

  ofs_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ofs_issue_seq #(.N_CFG(K), .CW(CW)) i_issue (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .ready (issue_ready),
    .valid (issue_valid),
    .cfg   (issue_cfg)
  );

  ofs_mask_gen #(.N_RES(N_RES), .N_CFG(K), .CW(CW)) i_mask (
    .en   (issue_valid),
    .cfg  (issue_cfg),
    .mask (issue_mask)
  );

  ofs_collect #(.N_CFG(K), .CW(CW)) i_collect (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .res_valid (res_valid),
    .res_cfg   (res_cfg),
    .res_pass  (res_pass),
    .done      (done),
    .pattern   (fault_idx),
    .dup_err   (dup_err)
  );

  // R6: no index is visible before completion
  a_r6_idx_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done |-> (fault_idx == '0));

endmodule

// File: tb/test_overlap_fault_locator.sv
module test_overlap_fault_locator;

  localparam int N_RES = 8;
  localparam int K     = 3;
  localparam int CW    = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic             issue_valid;
  logic             issue_ready;
  logic [CW-1:0]    issue_cfg;
  logic [N_RES-1:0] issue_mask;
  logic             res_valid;
  logic [CW-1:0]    res_cfg;
  logic             res_pass;
  logic             done;
  logic [K-1:0]     fault_idx;
  logic             dup_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  overlap_fault_locator #(.N_RES(N_RES)) i_overlap_fault_locator (
    .clk (clk), .rst_n (rst_n), .start (start),
    .issue_valid (issue_valid), .issue_ready (issue_ready),
    .issue_cfg (issue_cfg), .issue_mask (issue_mask),
    .res_valid (res_valid), .res_cfg (res_cfg), .res_pass (res_pass),
    .done (done), .fault_idx (fault_idx), .dup_err (dup_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp below 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic send(input int cfg, input bit pass);
    res_valid = 1'b1;
    res_cfg   = CW'(cfg);
    res_pass  = pass;
    step();
    res_valid = 1'b0;
  endtask

  function automatic logic [N_RES-1:0] exp_mask(input int cfg);
    logic [N_RES-1:0] m = '0;
    for (int r = 0; r < N_RES; r++) m[r] = (((r >> cfg) & 1) == 1);
    return m;
  endfunction

  initial begin
    rst_n = 1'b0; start = 1'b0; issue_ready = 1'b0;
    res_valid = 1'b0; res_cfg = '0; res_pass = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk(issue_valid == 1'b0, "R1 issue_valid", int'(issue_valid), 0);
    chk(done == 1'b0,        "R1 done",        int'(done), 0);
    chk(fault_idx == '0,     "R1 fault_idx",   int'(fault_idx), 0);
    chk(dup_err == 1'b0,     "R1 dup_err",     int'(dup_err), 0);

    // R9 results before any start are ignored
    for (int k = 0; k < K; k++) send(k, 1'b1);
    chk(done == 1'b0, "R9 pre-start results ignored", int'(done), 0);

    // R2 / R3 issue order, hold and masks
    pulse_start();
    chk(issue_valid && issue_cfg == 0, "R2 first offer", int'(issue_cfg), 0);
    chk(issue_mask == exp_mask(0), "R3 mask cfg0", int'(issue_mask), int'(exp_mask(0)));
    step();
    chk(issue_valid && issue_cfg == 0, "R2 hold while not ready", int'(issue_cfg), 0);
    issue_ready = 1'b1;
    for (int k = 1; k < K; k++) begin
      step();
      chk(issue_valid && int'(issue_cfg) == k, "R2 advance", int'(issue_cfg), k);
      chk(issue_mask == exp_mask(k), "R3 mask", int'(issue_mask), int'(exp_mask(k)));
    end
    step();
    chk(issue_valid == 1'b0, "R2 valid falls after last", int'(issue_valid), 0);
    chk(issue_mask == '0, "R3 mask zero when idle", int'(issue_mask), 0);
    issue_ready = 1'b0;

    // R4 / R5 / R6 exhaustive sweep over faulty index and arrival order
    for (int idx = 0; idx < N_RES; idx++) begin
      for (int ord = 0; ord < 3; ord++) begin
        pulse_start();
        for (int j = 0; j < K; j++) begin
          int k;
          k = (ord == 0) ? j : (ord == 1) ? (K - 1 - j) : ((j + 1) % K);
          if (j == K - 1) begin
            chk(done == 1'b0, "R5 done waits for last", int'(done), 0);
            chk(fault_idx == '0, "R6 idx hidden before done", int'(fault_idx), 0);
          end
          send(k, ((idx >> k) & 1) == 1);
        end
        chk(done == 1'b1, "R5 done after all", int'(done), 1);
        chk(int'(fault_idx) == idx, "R4 index assembled", int'(fault_idx), idx);
        chk(dup_err == 1'b0, "R7 no false error", int'(dup_err), 0);
      end
    end

    // R10 worked example and R7 duplicate after done
    pulse_start();
    send(0, 1'b1); send(1, 1'b0); send(2, 1'b0);
    chk(done && fault_idx == 3'd1, "R10 example idx", int'(fault_idx), 1);
    send(0, 1'b0);
    chk(dup_err == 1'b1, "R7 dup after done flagged", int'(dup_err), 1);
    chk(fault_idx == 3'd1, "R7 dup keeps bit", int'(fault_idx), 1);

    // R7 duplicate before done, R9 start clears error
    pulse_start();
    chk(dup_err == 1'b0, "R9 start clears dup_err", int'(dup_err), 0);
    send(1, 1'b1); send(1, 1'b0);
    chk(dup_err == 1'b1 && done == 1'b0, "R7 dup before done", int'(dup_err), 1);
    send(0, 1'b0); send(2, 1'b0);
    chk(done && fault_idx == 3'd2, "R7 first value retained", int'(fault_idx), 2);

    // R8 out-of-range tag ignored
    pulse_start();
    send(3, 1'b1);
    send(0, 1'b1); send(1, 1'b1);
    chk(done == 1'b0, "R8 tag 3 not counted", int'(done), 0);
    chk(dup_err == 1'b0, "R8 tag 3 no error", int'(dup_err), 0);
    send(2, 1'b0);
    chk(done && fault_idx == 3'd3, "R8 completes normally", int'(fault_idx), 3);

    // R9 result on the same edge as start is dropped
    start = 1'b1; res_valid = 1'b1; res_cfg = 2'd0; res_pass = 1'b1;
    step();
    start = 1'b0; res_valid = 1'b0;
    send(1, 1'b1); send(2, 1'b1);
    chk(done == 1'b0, "R9 same-edge result dropped", int'(done), 0);
    send(0, 1'b0);
    chk(done && fault_idx == 3'd6, "R9 later cfg0 accepted", int'(fault_idx), 6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule